// File: doc/BRIEF.md
# Serial Converter Control-Byte Front End

This block is the digital serial front end of a multi-channel sampling converter. While chip select is low, it watches a serial data line on every rising edge of the serial clock. Low bits are skipped until a high bit appears. That high bit opens a control byte. The seven bits that follow carry, MSB first, a three-bit channel address, a short-resolution request, an input-mode bit and a two-bit power field.

When the byte is complete, the block does four things:
- It latches the decoded fields.
- It raises a busy flag for one clock.
- It loads the conversion value from a parallel stand-in input.
- It shifts that value out MSB first, as 12 bits or as the upper 8 bits.

A new control byte may overlap the tail of the current result, which allows back-to-back conversions. Raising chip select aborts everything and returns the receiver to hunting. A power indication follows the power field. Reserved power codes are flagged and treated as sleep between conversions.

Top module: `ctlb_frontend`

## Requirements
- R1: While hunting, low bits on `din` are ignored. The first high bit sampled with `cs_n` low is taken as the start bit. No byte is decoded and `busy` stays low until seven more bits have been sampled.
- R2: The seven bits after the start bit are, in order: A2, A1, A0, length select, input-mode, P1, P0. `busy` is high for exactly the one cycle after the edge that samples P0.
- R3: When the input-mode bit is 1 (single-ended), `mux_pos` is one-hot at the index A2..A0 and `mux_neg` is all zero.
- R4: When the input-mode bit is 0 (differential), `mux_pos` is one-hot at index A and `mux_neg` is one-hot at index A XOR 1.
- R5: `mode_pin` is sampled with the last control bit. If `mode_pin` is low, the conversion is 12 bits and `res_short` is 0. If `mode_pin` is high, a length-select bit of 1 gives 8 bits (`res_short`=1) and 0 gives 12 bits.
- R6: Starting on the cycle after `busy`, `dout` carries the result MSB first, one bit per cycle. A 12-bit result is `conv_val[11:0]`; an 8-bit result is `conv_val[11:4]`. `dout` is 0 whenever no result is being shifted.
- R7: `pwr_on` is high from the cycle after the start bit through the last result bit. Afterwards it stays high only if the last decoded power field was 11.
- R8: Power codes 01 and 10 set `pd_rsvd`, which holds until the next decode. They behave like 00: `pwr_on` drops once the conversion is over.
- R9: A new start bit is accepted 14 clocks after the previous start in 12-bit mode and 10 clocks after it in 8-bit mode. A high bit that arrives one clock earlier is ignored.
- R10: `cs_n` high aborts the byte and the result. On the next cycle `busy` and `dout` are 0, and the receiver hunts again.
- R11: After reset, `busy`, `dout`, `mux_pos`, `mux_neg`, `res_short`, `pwr_on` and `pd_rsvd` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control input |
| mode_pin | input | 1 | Enables the 8-bit length option when high |
| conv_val | input | 12 | Stand-in conversion value |
| busy | output | 1 | One-cycle flag between control byte and data |
| dout | output | 1 | Serial result output, MSB first |
| mux_pos | output | 8 | One-hot positive input select |
| mux_neg | output | 8 | One-hot negative input select, zero when single-ended |
| res_short | output | 1 | Current conversion is 8 bits |
| pwr_on | output | 1 | Converter powered |
| pd_rsvd | output | 1 | Last power field was a reserved code |

## Verification
The bench builds the block with its default parameters: 12-bit and 8-bit result lengths and a three-bit channel address. This makes the full control space of 128 byte values small enough to sweep completely against both levels of `mode_pin`. Every channel, input mode, length and power code is therefore reached, and each result is compared with a word computed arithmetically from the byte.

Cycle-indexed windows then place second start bits exactly on, and one clock before, the earliest accepted clock for both lengths. They also raise chip select during a byte and during the result.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;
  localparam int CTL_ADDR_W = 3;
  localparam int CTL_NCH    = 1 << CTL_ADDR_W;
  localparam int CTL_BITS   = CTL_ADDR_W + 4;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_CTRL = 2'd1,
    RX_WAIT = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic [CTL_ADDR_W-1:0] addr;
    logic                  len_sel;
    logic                  sgl;
    logic [1:0]            pd;
  } ctl_fields_t;
endpackage

// File: rtl/ctlb_rst_sync.sv
module ctlb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ctlb_rx.sv
module ctlb_rx
  import ctlb_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int RES_SHORT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        din,
  input  logic        short_q,
  output ctl_fields_t fields,
  output logic        byte_done,
  output logic        busy,
  output logic        active
);
  localparam int GAP_LONG  = RES_W + 2;
  localparam int GAP_SHORT = RES_SHORT_W + 2;
  localparam int CNT_W     = $clog2(GAP_LONG + 1);
  localparam int BIT_W     = $clog2(CTL_BITS);

  rx_state_e             state_q, state_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [CNT_W-1:0]      since_q, since_d;
  logic [CTL_BITS-2:0]   sr_q, sr_d;
  logic                  busy_q;
  logic                  done;
  logic [CNT_W-1:0]      gap_last;

  assign gap_last = short_q ? CNT_W'(GAP_SHORT - 1) : CNT_W'(GAP_LONG - 1);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    since_d = since_q;
    sr_d    = sr_q;
    done    = 1'b0;
    if (cs_n) begin
      state_d = RX_HUNT;
      bit_d   = '0;
      since_d = '0;
    end else begin
      unique case (state_q)
        RX_HUNT: begin
          if (din) begin
            state_d = RX_CTRL;
            bit_d   = '0;
            since_d = CNT_W'(1);
          end
        end
        RX_CTRL: begin
          sr_d    = {sr_q[CTL_BITS-3:0], din};
          since_d = since_q + CNT_W'(1);
          if (bit_q == BIT_W'(CTL_BITS - 1)) begin
            done    = 1'b1;
            state_d = RX_WAIT;
          end else begin
            bit_d = bit_q + BIT_W'(1);
          end
        end
        RX_WAIT: begin
          since_d = since_q + CNT_W'(1);
          if (since_q == gap_last) state_d = RX_HUNT;
        end
        default: state_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      bit_q   <= '0;
      since_q <= '0;
      sr_q    <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      since_q <= since_d;
      sr_q    <= sr_d;
      busy_q  <= done;
    end
  end

  assign fields    = ctl_fields_t'({sr_q[CTL_BITS-2:0], din});
  assign byte_done = done;
  assign busy      = busy_q;
  assign active    = (state_q != RX_HUNT);
endmodule

// File: rtl/ctlb_decode.sv
module ctlb_decode
  import ctlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  ctl_fields_t        fields,
  input  logic               mode_pin,
  output logic [CTL_NCH-1:0] mux_pos,
  output logic [CTL_NCH-1:0] mux_neg,
  output logic               short_q,
  output logic               keep_on,
  output logic               pd_rsvd
);
  logic [CTL_NCH-1:0] pos_d, neg_d;
  logic [CTL_NCH-1:0] pos_q, neg_q;
  logic               short_d, keep_d, rsvd_d;
  logic               short_r, keep_r, rsvd_r;

  for (genvar g = 0; g < CTL_NCH; g++) begin : g_chan
    assign pos_d[g] = (fields.addr == CTL_ADDR_W'(g));
    assign neg_d[g] = !fields.sgl && (fields.addr == CTL_ADDR_W'(g ^ 1));
  end

  assign short_d = mode_pin & fields.len_sel;
  assign keep_d  = (fields.pd == 2'b11);
  assign rsvd_d  = (fields.pd == 2'b01) || (fields.pd == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      neg_q   <= '0;
      short_r <= 1'b0;
      keep_r  <= 1'b0;
      rsvd_r  <= 1'b0;
    end else if (load) begin
      pos_q   <= pos_d;
      neg_q   <= neg_d;
      short_r <= short_d;
      keep_r  <= keep_d;
      rsvd_r  <= rsvd_d;
    end
  end

  assign mux_pos = pos_q;
  assign mux_neg = neg_q;
  assign short_q = short_r;
  assign keep_on = keep_r;
  assign pd_rsvd = rsvd_r;
endmodule

// File: rtl/ctlb_shift.sv
module ctlb_shift #(
  parameter int RES_W       = 12,
  parameter int RES_SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             load,
  input  logic             short_sel,
  input  logic [RES_W-1:0] conv_val,
  output logic             dout,
  output logic             shifting
);
  localparam int CNT_W = $clog2(RES_W + 1);
  localparam int PAD_W = RES_W - RES_SHORT_W;

  logic [RES_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (cs_n) begin
      cnt_d = '0;
    end else if (load) begin
      if (short_sel) begin
        sh_d  = {conv_val[RES_W-1 -: RES_SHORT_W], {PAD_W{1'b0}}};
        cnt_d = CNT_W'(RES_SHORT_W);
      end else begin
        sh_d  = conv_val;
        cnt_d = CNT_W'(RES_W);
      end
    end else if (cnt_q != '0) begin
      sh_d  = {sh_q[RES_W-2:0], 1'b0};
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign shifting = (cnt_q != '0);
  assign dout     = shifting & sh_q[RES_W-1];
endmodule

// File: rtl/ctlb_frontend.sv
module ctlb_frontend
  import ctlb_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int RES_SHORT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               din,
  input  logic               mode_pin,
  input  logic [RES_W-1:0]   conv_val,
  output logic               busy,
  output logic               dout,
  output logic [CTL_NCH-1:0] mux_pos,
  output logic [CTL_NCH-1:0] mux_neg,
  output logic               res_short,
  output logic               pwr_on,
  output logic               pd_rsvd
);
  logic        rst_n_int;
  ctl_fields_t fields;
  logic        byte_done;
  logic        rx_active;
  logic        short_q;
  logic        keep_on;
  logic        shifting;
  logic        conv_act;

  ctlb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ctlb_rx #(.RES_W(RES_W), .RES_SHORT_W(RES_SHORT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cs_n      (cs_n),
    .din       (din),
    .short_q   (short_q),
    .fields    (fields),
    .byte_done (byte_done),
    .busy      (busy),
    .active    (rx_active)
  );

  ctlb_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (byte_done),
    .fields   (fields),
    .mode_pin (mode_pin),
    .mux_pos  (mux_pos),
    .mux_neg  (mux_neg),
    .short_q  (short_q),
    .keep_on  (keep_on),
    .pd_rsvd  (pd_rsvd)
  );

  ctlb_shift #(.RES_W(RES_W), .RES_SHORT_W(RES_SHORT_W)) u_sh (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cs_n      (cs_n),
    .load      (busy),
    .short_sel (short_q),
    .conv_val  (conv_val),
    .dout      (dout),
    .shifting  (shifting)
  );

  assign conv_act  = rx_active | shifting;
  assign pwr_on    = keep_on | conv_act;
  assign res_short = short_q;
endmodule

// File: rtl/ctlb_frontend_chk.sv
module ctlb_frontend_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           mode_pin,
  input logic           busy,
  input logic           dout,
  input logic [NCH-1:0] mux_pos,
  input logic [NCH-1:0] mux_neg,
  input logic           res_short,
  input logic           pwr_on,
  input logic           pd_rsvd,
  input logic           conv_act
);
  assert_busy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_pos_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mux_pos));

  assert_neg_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mux_neg) && ((mux_neg & mux_pos) == '0));

  assert_pin_forces_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(mode_pin)) |-> !res_short);

  assert_power_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pwr_on);

  assert_rsvd_sleeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_rsvd && !conv_act) |-> !pwr_on);

  assert_cs_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!busy && !dout));
endmodule

bind ctlb_frontend ctlb_frontend_chk #(.NCH(ctlb_pkg::CTL_NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .mode_pin  (mode_pin),
  .busy      (busy),
  .dout      (dout),
  .mux_pos   (mux_pos),
  .mux_neg   (mux_neg),
  .res_short (res_short),
  .pwr_on    (pwr_on),
  .pd_rsvd   (pd_rsvd),
  .conv_act  (conv_act)
);

// File: tb/sim_ctlb_frontend.sv
`timescale 1ns/1ps
module sim_ctlb_frontend;
  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        din;
  logic        mode_pin;
  logic [11:0] conv_val;
  logic        busy;
  logic        dout;
  logic [7:0]  mux_pos;
  logic [7:0]  mux_neg;
  logic        res_short;
  logic        pwr_on;
  logic        pd_rsvd;

  int n_chk;
  int n_fail;

  logic din_v  [0:47];
  logic cs_v   [0:47];
  logic busy_o [0:47];
  logic dout_o [0:47];

  ctlb_frontend u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .din       (din),
    .mode_pin  (mode_pin),
    .conv_val  (conv_val),
    .busy      (busy),
    .dout      (dout),
    .mux_pos   (mux_pos),
    .mux_neg   (mux_neg),
    .res_short (res_short),
    .pwr_on    (pwr_on),
    .pd_rsvd   (pd_rsvd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic clear_win();
    for (int k = 0; k < 48; k++) begin
      din_v[k] = 1'b0;
      cs_v[k]  = 1'b0;
    end
  endtask

  task automatic put_byte(input int s, input logic [6:0] c);
    din_v[s] = 1'b1;
    for (int j = 0; j < 7; j++) din_v[s+1+j] = c[6-j];
  endtask

  task automatic run_win();
    for (int k = 0; k < 48; k++) begin
      cs_n = cs_v[k];
      din  = din_v[k];
      @(negedge clk);
      busy_o[k] = busy;
      dout_o[k] = dout;
    end
    cs_n = 1'b1;
    din  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int busy_count();
    int n = 0;
    for (int k = 0; k < 48; k++) if (busy_o[k]) n++;
    return n;
  endfunction

  function automatic logic [11:0] collect(input int first, input int n);
    logic [11:0] w = '0;
    for (int k = 0; k < n; k++) w = {w[10:0], dout_o[first+k]};
    return w;
  endfunction

  task automatic frame(input logic [6:0] c, input logic mp);
    logic [11:0] v;
    logic [11:0] exp_w;
    logic [11:0] got;
    logic [7:0]  exp_pos;
    logic [7:0]  exp_neg;
    int          n;
    v       = 12'((int'(c) * 37) + (int'(mp) * 1111) + 5);
    n       = (mp && c[3]) ? 8 : 12;
    exp_w   = (n == 12) ? v : {4'b0, v[11:4]};
    exp_pos = 8'(1) << c[6:4];
    exp_neg = c[2] ? 8'h00 : (8'(1) << (c[6:4] ^ 3'd1));
    mode_pin = mp;
    conv_val = v;
    cs_n = 1'b0;
    din  = 1'b0;
    repeat (int'(c) % 3) @(negedge clk);
    din = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after start", int'(busy), 0);
    for (int i = 6; i >= 0; i--) begin
      din = c[i];
      @(negedge clk);
    end
    din = 1'b0;
    chk(busy == 1'b1, "R2 busy after byte", int'(busy), 1);
    chk(mux_pos == exp_pos, "R3 mux_pos", int'(mux_pos), int'(exp_pos));
    chk(mux_neg == exp_neg, "R4 mux_neg", int'(mux_neg), int'(exp_neg));
    chk(res_short == (n == 8), "R5 res_short", int'(res_short), int'(n == 8));
    chk(pd_rsvd == (c[1:0] == 2'b01 || c[1:0] == 2'b10), "R8 pd_rsvd",
        int'(pd_rsvd), int'(c[1:0] == 2'b01 || c[1:0] == 2'b10));
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got = {got[10:0], dout};
      if (i == 0) chk(pwr_on == 1'b1, "R7 pwr_on during data", int'(pwr_on), 1);
    end
    chk(got == exp_w, "R6 result word", int'(got), int'(exp_w));
    @(negedge clk);
    chk(dout == 1'b0 && busy == 1'b0, "R6 dout idle after result",
        int'({busy, dout}), 0);
    chk(pwr_on == (c[1:0] == 2'b11), "R7 R8 pwr_on after conversion",
        int'(pwr_on), int'(c[1:0] == 2'b11));
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    cs_n     = 1'b1;
    din      = 1'b0;
    mode_pin = 1'b0;
    conv_val = 12'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk({busy, dout, res_short, pwr_on, pd_rsvd} == 5'b0, "R11 reset flags",
        int'({busy, dout, res_short, pwr_on, pd_rsvd}), 0);
    chk(mux_pos == 8'h00 && mux_neg == 8'h00, "R11 reset mux",
        int'({mux_pos, mux_neg}), 0);

    // R1..R8: every control byte with both mode pin levels
    for (int mp = 0; mp < 2; mp++)
      for (int c = 0; c < 128; c++)
        frame(7'(c), 1'(mp));

    // R9: 12-bit, second start exactly 14 clocks later
    mode_pin = 1'b0;
    conv_val = 12'hA5C;
    clear_win();
    put_byte(0, 7'b000_0_1_11);
    put_byte(14, 7'b101_0_1_11);
    run_win();
    chk(busy_o[7] == 1'b1 && busy_o[21] == 1'b1, "R9 long overlap busy",
        int'({busy_o[7], busy_o[21]}), 3);
    chk(busy_count() == 2, "R9 long overlap count", busy_count(), 2);
    chk(collect(8, 12) == 12'hA5C, "R6 R9 first result during overlap",
        int'(collect(8, 12)), 'hA5C);
    chk(collect(22, 12) == 12'hA5C, "R6 R9 second result",
        int'(collect(22, 12)), 'hA5C);
    chk(mux_pos == 8'h20, "R9 R3 second byte decoded", int'(mux_pos), 'h20);

    // R9: 12-bit, high bit one clock early is ignored
    clear_win();
    put_byte(0, 7'b000_0_1_11);
    din_v[13] = 1'b1;
    run_win();
    chk(busy_count() == 1, "R9 long early start ignored", busy_count(), 1);

    // R9: 8-bit, second start 10 clocks later
    mode_pin = 1'b1;
    conv_val = 12'h3C9;
    clear_win();
    put_byte(0, 7'b011_1_1_11);
    put_byte(10, 7'b110_1_0_00);
    run_win();
    chk(busy_o[7] == 1'b1 && busy_o[17] == 1'b1, "R9 short overlap busy",
        int'({busy_o[7], busy_o[17]}), 3);
    chk(busy_count() == 2, "R9 short overlap count", busy_count(), 2);
    chk(collect(8, 8) == 12'h03C, "R6 R9 short result", int'(collect(8, 8)), 'h03C);
    chk(mux_pos == 8'h40 && mux_neg == 8'h80, "R4 R9 differential second byte",
        int'({mux_pos, mux_neg}), 'h4080);

    // R9: 8-bit, early high bit ignored
    clear_win();
    put_byte(0, 7'b011_1_1_11);
    din_v[9] = 1'b1;
    run_win();
    chk(busy_count() == 1, "R9 short early start ignored", busy_count(), 1);

    // R10: abort inside a byte, then a fresh byte decodes
    mode_pin = 1'b0;
    clear_win();
    put_byte(0, 7'b111_0_0_11);
    cs_v[4] = 1'b1;
    put_byte(6, 7'b001_0_1_00);
    run_win();
    chk(busy_count() == 1 && busy_o[13] == 1'b1, "R10 abort restarts hunting",
        busy_count(), 1);
    chk(mux_pos == 8'h02 && mux_neg == 8'h00, "R10 R3 byte after abort",
        int'({mux_pos, mux_neg}), 'h0200);

    // R10: abort during result shifting
    conv_val = 12'hFFF;
    clear_win();
    put_byte(0, 7'b000_0_1_11);
    cs_v[12] = 1'b1;
    run_win();
    chk(dout_o[11] == 1'b1, "R6 result before abort", int'(dout_o[11]), 1);
    begin
      int ones = 0;
      for (int k = 12; k < 48; k++) if (dout_o[k]) ones++;
      chk(ones == 0, "R10 dout silent after abort", ones, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule